// File: doc/BRIEF.md
# Selectable SCL Rate Divider

This block derives a serial-bus clock from a fixed system clock. A 2-bit select code picks one of four fixed division ratios. With the default settings and a 1.5 MHz input, code 0 gives 100 kHz, code 1 gives about 88.2 kHz, code 2 gives about 44.1 kHz and code 3 gives 1.5 kHz. The chosen ratio is loaded into a down-counter as its preload value, and the counter reloads itself at the end of every output period. Only one rate is active at a time.

The divided clock has an exact 50% duty cycle for both even and odd ratios. For an odd ratio N, a rising-edge phase stays high for (N-1)/2 input cycles. A copy of that phase is taken on the falling edge of the input clock, and the OR of the two phases stretches the high time by half an input cycle, to N/2. A companion tick output marks every output edge, so that a bus controller in the same clock domain can schedule its data changes.

A change of select is applied only at the next reload, so no runt pulse is produced. While enable is low, the output is held low and the counter waits at the preload value. The reset input is active low and asynchronous. It is expected to be released synchronously to the clock by the surrounding reset tree.

Top module: `scl_rate_div`

## Requirements
- R1: With enable held high, the output period is N input clock cycles, where N is set by the select code: code 0 gives 15, code 1 gives 17, code 2 gives 34 and code 3 gives 1000 (default parameters).
- R2: In every period the output is high for exactly N half-cycles of the input clock, which is a 50% duty cycle for odd and even N. For odd N the output falls on a falling edge of the input clock.
- R3: The tick output is high for exactly one input clock cycle for each output edge, which gives two ticks per period. That cycle begins at the rising input edge that starts the output transition, and the output transition lies inside that cycle.
- R4: A change of the select code during a period does not change that period. The new ratio takes effect from the next counter reload.
- R5: From the first rising edge that samples enable low, the output reaches low within that input cycle and stays low while enable stays low. A forced fall of this kind also raises the tick.
- R6: While enable is low, the counter is held at the preload of the current select code. The output therefore rises on the first rising edge that samples enable high, and the period that follows has the full length N.
- R7: While reset is asserted the output and the tick are low. With enable high, the first output rise comes on the second rising clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; both of its edges are used |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en | input | 1 | Run enable; while low, the output is held low |
| rate_sel | input | 2 | Division ratio select code |
| scl_clk | output | 1 | Divided clock with 50% duty cycle |
| scl_tick | output | 1 | One-cycle pulse for each edge of scl_clk |

## Verification
The two functions that can land in the same input cycle are the forced fall caused by a drop of enable and the half-cycle extension used for odd ratios. The falling-edge phase still holds the output high for half a cycle after the rising-edge phase has been cleared. This is provoked by dropping enable one cycle after an output rise with the 17 ratio selected. The output and the tick are then sampled after both the rising and the falling input edge: the output must still be high after the rising edge, must be low after the falling edge, and the tick must mark the fall. A select change made just after an output rise is judged by the length of that period and of the period after it.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

  localparam int unsigned SEL_W     = 2;
  localparam int unsigned NUM_RATES = 1 << SEL_W;

  function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic int unsigned bits_to_hold(input int unsigned v);
    return $clog2(v + 1);
  endfunction

endpackage

// File: rtl/scl_rate_table.sv
module scl_rate_table
  import scl_div_pkg::*;
#(
  parameter int unsigned DIV0  = 15,
  parameter int unsigned DIV1  = 17,
  parameter int unsigned DIV2  = 34,
  parameter int unsigned DIV3  = 1000,
  parameter int unsigned CNT_W = 10
) (
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] div,
  output logic             odd
);

  localparam int unsigned RATIO [NUM_RATES] = '{DIV0, DIV1, DIV2, DIV3};

  logic [CNT_W-1:0] lut [NUM_RATES];

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
    assign lut[g] = CNT_W'(RATIO[g]);
  end

  assign div = lut[sel];
  assign odd = div[0];

endmodule

// File: rtl/scl_div_counter.sv
module scl_div_counter #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] load_div,
  input  logic             load_odd,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] div_q,
  output logic             odd_q,
  output logic             primed_q
);

  logic             reload;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] div_d;
  logic             odd_d;

  // Reload while stopped, on the first edge after reset, and at wrap.
  always_comb begin
    reload = !en || !primed_q || (cnt_q == '0);
    if (reload) begin
      cnt_d = load_div - CNT_W'(1);
      div_d = load_div;
      odd_d = load_odd;
    end else begin
      cnt_d = cnt_q - CNT_W'(1);
      div_d = div_q;
      odd_d = odd_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      div_q    <= '0;
      odd_q    <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      primed_q <= 1'b1;
      if (reload) begin
        div_q <= div_d;
        odd_q <= odd_d;
      end
    end
  end

endmodule

// File: rtl/scl_div_phase.sv
module scl_div_phase #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] div_q,
  input  logic             odd_q,
  output logic             scl_clk,
  output logic             tick
);

  logic [CNT_W-1:0] thresh;
  logic             hi_d;
  logic             hi_q;
  logic             tick_d;
  logic             tick_q;
  logic             late_q;

  // The early phase is high for floor(N/2) counts from the preload.
  always_comb begin
    thresh = div_q - (div_q >> 1);
    hi_d   = run && (cnt_q >= thresh);
    tick_d = hi_d ^ hi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      hi_q   <= hi_d;
      tick_q <= tick_d;
    end
  end

  // Half-cycle copy that stretches the high time for odd ratios.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      late_q <= 1'b0;
    end else begin
      late_q <= hi_q;
    end
  end

  assign scl_clk = hi_q | (late_q & odd_q);
  assign tick    = tick_q;

endmodule

// File: rtl/scl_rate_div.sv
module scl_rate_div
  import scl_div_pkg::*;
#(
  parameter int unsigned DIV0 = 15,
  parameter int unsigned DIV1 = 17,
  parameter int unsigned DIV2 = 34,
  parameter int unsigned DIV3 = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] rate_sel,
  output logic       scl_clk,
  output logic       scl_tick
);

  localparam int unsigned DIV_MAX = max_of4(DIV0, DIV1, DIV2, DIV3);
  localparam int unsigned CNT_W   = bits_to_hold(DIV_MAX);

  logic [CNT_W-1:0] sel_div;
  logic             sel_odd;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] div_q;
  logic             odd_q;
  logic             primed_q;
  logic             run;

  scl_rate_table #(
    .DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3), .CNT_W(CNT_W)
  ) u_table (
    .sel (rate_sel),
    .div (sel_div),
    .odd (sel_odd)
  );

  scl_div_counter #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .load_div (sel_div),
    .load_odd (sel_odd),
    .cnt_q    (cnt_q),
    .div_q    (div_q),
    .odd_q    (odd_q),
    .primed_q (primed_q)
  );

  assign run = en && primed_q;

  scl_div_phase #(.CNT_W(CNT_W)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .cnt_q   (cnt_q),
    .div_q   (div_q),
    .odd_q   (odd_q),
    .scl_clk (scl_clk),
    .tick    (scl_tick)
  );

endmodule

// File: rtl/scl_rate_div_chk.sv
module scl_rate_div_chk #(
  parameter int unsigned CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             scl_clk,
  input logic             scl_tick,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] div_q,
  input logic             primed_q
);

  // R1: once loaded, the counter stays below the active ratio
  assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    primed_q |-> (cnt_q < div_q));

  // R3: a tick exactly when the output changed in the last cycle
  assert_tick_marks_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    scl_tick == (scl_clk != $past(scl_clk)));

  // R4: the active ratio is kept until a reload point
  assert_ratio_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && $past(primed_q) && ($past(cnt_q) != '0)) |-> $stable(div_q));

  // R5: output low one cycle after enable is sampled low
  assert_off_when_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> !scl_clk);

  // R6: stopped counter waits at the preload
  assert_hold_at_preload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && !$past(en)) |-> (cnt_q == div_q - CNT_W'(1)));

endmodule

bind scl_rate_div scl_rate_div_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .scl_clk  (scl_clk),
  .scl_tick (scl_tick),
  .cnt_q    (cnt_q),
  .div_q    (div_q),
  .primed_q (primed_q)
);

// File: tb/scl_rate_div_test.sv
`timescale 1ns/1ps
module scl_rate_div_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1;
  logic [1:0] rate_sel = 2'd0;
  logic       scl_clk;
  logic       scl_tick;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic prev_s = 1'b0;
  logic cur_s = 1'b0;

  localparam int unsigned VSEL [4] = '{0, 1, 2, 3};
  localparam int unsigned VDIV [4] = '{15, 17, 34, 1000};

  always #2 clk = ~clk;

  scl_rate_div uut (
    .clk(clk), .rst_n(rst_n), .en(en), .rate_sel(rate_sel),
    .scl_clk(scl_clk), .scl_tick(scl_tick)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One sample 1 ns after each clock edge, rising or falling.
  task automatic smp();
    @(posedge clk or negedge clk);
    #1;
    prev_s = cur_s;
    cur_s  = scl_clk;
  endtask

  task automatic wait_rise();
    for (int i = 0; i < 6000; i++) begin
      smp();
      if (!prev_s && cur_s) return;
    end
  endtask

  // Starts on a rise sample, ends on the next rise sample.
  task automatic measure(output int per, output int hi, output int tk);
    per = 0; hi = 0; tk = 0;
    for (int i = 0; i < 6000; i++) begin
      per++;
      if (cur_s) hi++;
      if (clk && scl_tick) tk++;
      smp();
      if (!prev_s && cur_s) return;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int per, hi, tk;
    // R7: reset state
    repeat (3) @(posedge clk);
    #1;
    chk(scl_clk == 1'b0, "R7 reset clk", scl_clk, 0);
    chk(scl_tick == 1'b0, "R7 reset tick", scl_tick, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(scl_clk == 1'b0, "R7 edge1 low", scl_clk, 0);
    @(posedge clk); #1;
    chk(scl_clk == 1'b1, "R7 edge2 rise", scl_clk, 1);
    cur_s = scl_clk;

    // R1 R2 R3: walk the rate table
    for (int v = 0; v < 4; v++) begin
      en = 1'b0;
      rate_sel = 2'(VSEL[v]);
      repeat (3) @(posedge clk);
      #1;
      en = 1'b1;
      cur_s = scl_clk;
      wait_rise();
      measure(per, hi, tk);
      chk(per == 2 * VDIV[v], "R1 period", per, 2 * VDIV[v]);
      chk(hi == VDIV[v], "R2 high half-cycles", hi, VDIV[v]);
      chk(tk == 2, "R3 ticks per period", tk, 2);
    end

    // R5 R6: hold low while disabled, restart at once
    en = 1'b0;
    rate_sel = 2'd2;
    repeat (2) @(posedge clk);
    #1;
    hi = 0;
    for (int i = 0; i < 20; i++) begin
      smp();
      if (cur_s) hi++;
    end
    chk(hi == 0, "R5 held low", hi, 0);
    @(posedge clk); #1;
    en = 1'b1;
    @(posedge clk); #1;
    chk(scl_clk == 1'b1, "R6 immediate rise", scl_clk, 1);
    cur_s = scl_clk;
    measure(per, hi, tk);
    chk(per == 68, "R6 full first period", per, 68);

    // R4: select change mid-period applies at the next reload
    rate_sel = 2'd0;
    wait_rise();
    wait_rise();
    rate_sel = 2'd3;
    measure(per, hi, tk);
    chk(per == 30, "R4 old ratio kept", per, 30);
    measure(per, hi, tk);
    chk(per == 2000, "R4 new ratio used", per, 2000);

    // R5 R3: disable while high with an odd ratio
    rate_sel = 2'd1;
    wait_rise();
    wait_rise();
    en = 1'b0;
    @(posedge clk); #1;
    chk(scl_tick == 1'b1, "R3 tick on forced fall", scl_tick, 1);
    chk(scl_clk == 1'b1, "R5 late phase still high", scl_clk, 1);
    @(negedge clk); #1;
    chk(scl_clk == 1'b0, "R5 low after falling edge", scl_clk, 0);
    @(posedge clk); #1;
    chk(scl_clk == 1'b0, "R5 stays low", scl_clk, 0);
    chk(scl_tick == 1'b0, "R3 single tick", scl_tick, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule